// File: doc/BRIEF.md
# Command-Sequence Write Guard

This block stands between the write capture stage of a byte-wide non-volatile memory and its storage array. Each cycle with the write strobe high delivers one captured (address, data) pair. The block watches this stream for fixed command patterns and keeps a protection flag. For every write it decides two things: whether the byte is a command byte, and whether the byte may be stored.

All command patterns share a three-pair opening. After the first two pairs, the data of the third pair picks the path. One value completes the three-step arming prefix. This turns protection on and lets the single write that follows through. The other value leads into a six-step release sequence, which turns protection off. Command bytes are never stored, whether protection is on or off.

The permit and command outputs are combinational on the presented write. The protection flag changes on the clock edge that accepts the final command byte.

Top module: `swp_guard`

## Requirements
- R1: After synchronous active-low reset, protection is off, the matcher is idle and no write is armed, so an ordinary write is permitted at once.
- R2: While protection is off, a write that is not a command byte has `wr_permit` high and `cmd_byte` low in the same cycle.
- R3: Any write that the matcher takes as a command step has `cmd_byte` high and `wr_permit` low.
- R4: The arming prefix is (13'h1555, 8'hAA), (13'h0AAA, 8'h55), (13'h1555, 8'hA0), given on consecutive writes. On the edge that accepts the third pair, `prot_on` goes high.
- R5: The first write after the arming prefix is permitted even while protection is on. The write after it is blocked.
- R6: While protection is on and no write is armed, every non-command write has `wr_permit` low.
- R7: The release sequence is (13'h1555, 8'hAA), (13'h0AAA, 8'h55), (13'h1555, 8'h80), (13'h1555, 8'hAA), (13'h0AAA, 8'h55), (13'h1555, 8'h20). It clears `prot_on` on the edge that accepts its sixth pair. None of its six bytes is permitted.
- R8: A write that does not match the expected step returns the matcher to idle. That write is then checked as a first step: (13'h1555, 8'hAA) starts a new sequence and is a command byte; anything else is an ordinary write.
- R9: At the third step, data 8'hA0 completes the arming prefix, 8'h80 continues toward release, and any other data counts as a mismatch.
- R10: The armed write takes priority over command recognition. If it equals the first command pair, it is permitted, `cmd_byte` stays low and no sequence starts.
- R11: Cycles with `wr_valid` low leave the matcher step, the armed state and the protection flag unchanged, and drive both `wr_permit` and `cmd_byte` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A captured write is presented this cycle |
| wr_addr | input | 13 | Captured write address |
| wr_data | input | 8 | Captured write data |
| wr_permit | output | 1 | Store the presented byte |
| cmd_byte | output | 1 | Presented byte is consumed as a command step |
| prot_on | output | 1 | Protection flag |

## Verification
Two functions can claim the same cycle: consuming the armed write, and recognising the first command pair. They collide when the write right after an arming prefix is itself (13'h1555, 8'hAA). A directed case provokes this, and the random stream, biased toward command pairs, produces it again by chance. The outcome is judged by expecting a permitted, non-command byte. The write after it is then checked for being blocked, and the one after that for being treated as a fresh first step. This shows that no sequence was started by the armed byte.

// File: rtl/swp_pkg.sv
// Shared constants for the command-sequence write guard.
// Assumes the default widths of a 13-bit address and an 8-bit data bus.
package swp_pkg;
    localparam int NUM_STEPS = 6;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int ARM_STEP  = 2;                 // step where the path forks
    typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/swp_matcher.sv
// Step matcher: follows the shared three-pair opening, forks on the third
// data byte, and follows the release tail. It reports which write is a
// command byte and when either path completes. It assumes the caller
// masks `wr_go` while an armed data write is being consumed.
module swp_matcher
    import swp_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_HI  = 13'h1555,
    parameter logic [ADDR_W-1:0] ADDR_LO  = 13'h0AAA,
    parameter logic [DATA_W-1:0] KEY_ONE  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_TWO  = 8'h55,
    parameter logic [DATA_W-1:0] KEY_ARM  = 8'hA0,
    parameter logic [DATA_W-1:0] KEY_ESC  = 8'h80,
    parameter logic [DATA_W-1:0] KEY_FREE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              is_cmd,
    output logic              arm_done,
    output logic              free_done
);
    localparam step_t LAST_STEP = step_t'(NUM_STEPS - 1);
    localparam step_t FORK_STEP = step_t'(ARM_STEP);

    step_t step_q, step_d;
    logic  step_hit, first_hit;

    // Pair expected at the current step; the fork step accepts two keys.
    always_comb begin
        unique case (step_q)
            3'd0, 3'd3: step_hit = (addr == ADDR_HI) && (data == KEY_ONE);
            3'd1, 3'd4: step_hit = (addr == ADDR_LO) && (data == KEY_TWO);
            3'd2:       step_hit = (addr == ADDR_HI) &&
                                   ((data == KEY_ARM) || (data == KEY_ESC));
            3'd5:       step_hit = (addr == ADDR_HI) && (data == KEY_FREE);
            default:    step_hit = 1'b0;
        endcase
    end

    // Restart check: a mismatching byte may still be a new first step.
    always_comb first_hit = (addr == ADDR_HI) && (data == KEY_ONE);

    // Next step, command flag and completion pulses.
    always_comb begin
        step_d    = step_q;
        is_cmd    = 1'b0;
        arm_done  = 1'b0;
        free_done = 1'b0;
        if (wr_go) begin
            if (step_hit) begin
                is_cmd = 1'b1;
                if (step_q == FORK_STEP && data == KEY_ARM) begin
                    arm_done = 1'b1;
                    step_d   = '0;
                end else if (step_q == LAST_STEP) begin
                    free_done = 1'b1;
                    step_d    = '0;
                end else begin
                    step_d = step_q + step_t'(1);
                end
            end else if (first_hit) begin
                is_cmd = 1'b1;
                step_d = step_t'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST_STEP);                                        // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable(step_q));                                 // R11
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm_done && free_done));                                   // R9
endmodule

// File: rtl/swp_state.sv
// Protection flag and one-shot arm. The arming prefix sets both. The
// release sequence clears the flag. The armed write clears the arm.
// It assumes the completion pulses come from the matcher and are exclusive.
module swp_state (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic arm_done,
    input  logic free_done,
    output logic prot_q,
    output logic armed_q
);
    // Flag and arm registers; off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (arm_done)               prot_q <= 1'b1;
            else if (free_done)         prot_q <= 1'b0;
            if (arm_done)               armed_q <= 1'b1;
            else if (wr_valid)          armed_q <= 1'b0;
        end
    end

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_done |=> (prot_q && armed_q));                           // R4
    AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        free_done |=> !prot_q);                                      // R7
    AST_ARM_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wr_valid) |=> !armed_q);                         // R5
    AST_ARM_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> prot_q);                                         // R5
endmodule

// File: rtl/swp_guard.sv
// Top of the command-sequence write guard. It combines the step matcher
// and the protection state into the per-write permit decision. It assumes
// one captured write per cycle when wr_valid is high.
module swp_guard #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_permit,
    output logic              cmd_byte,
    output logic              prot_on
);
    logic prot_q, armed_q, is_cmd, arm_done, free_done, match_go;

    // Armed write is data: keep it away from the matcher.
    always_comb match_go = wr_valid && !armed_q;

    swp_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (match_go),
        .addr      (wr_addr),
        .data      (wr_data),
        .is_cmd    (is_cmd),
        .arm_done  (arm_done),
        .free_done (free_done)
    );

    swp_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .arm_done  (arm_done),
        .free_done (free_done),
        .prot_q    (prot_q),
        .armed_q   (armed_q)
    );

    // Permit decision for the presented write.
    always_comb begin
        cmd_byte  = is_cmd;
        wr_permit = wr_valid && !is_cmd && (!prot_q || armed_q);
        prot_on   = prot_q;
    end

    AST_CMD_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_byte |-> !wr_permit);                                    // R3
    AST_ARMED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wr_valid) |-> (wr_permit && !cmd_byte));         // R10
endmodule

// File: tb/swp_guard_tb.sv
module swp_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_permit, cmd_byte, prot_on;

    int n_cmp = 0;
    int n_bad = 0;

    int  m_step = 0;
    bit  m_prot = 0;
    bit  m_armed = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    swp_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_permit(wr_permit), .cmd_byte(cmd_byte),
        .prot_on(prot_on)
    );

    function automatic bit pair_ok(int s, logic [12:0] a, logic [7:0] d);
        case (s)
            0, 3: return a == 13'h1555 && d == 8'hAA;
            1, 4: return a == 13'h0AAA && d == 8'h55;
            2:    return a == 13'h1555 && (d == 8'hA0 || d == 8'h80);
            5:    return a == 13'h1555 && d == 8'h20;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Present one cycle, compare against the model, then advance the model.
    task automatic cyc(string tag, bit v, logic [12:0] a, logic [7:0] d);
        bit e_cmd, e_perm;
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_data = d;
        #1;
        e_cmd = 0; e_perm = 0;
        check(tag, "prot_on", prot_on, m_prot);
        if (v) begin
            if (m_armed) begin
                e_perm = 1; m_armed = 0;
            end else if (pair_ok(m_step, a, d)) begin
                e_cmd = 1;
                if (m_step == 2 && d == 8'hA0) begin
                    m_prot = 1; m_armed = 1; m_step = 0;
                end else if (m_step == 5) begin
                    m_prot = 0; m_step = 0;
                end else m_step++;
            end else if (pair_ok(0, a, d)) begin
                e_cmd = 1; m_step = 1;
            end else begin
                e_perm = !m_prot; m_step = 0;
            end
        end
        check(tag, "cmd_byte", cmd_byte, e_cmd);
        check(tag, "wr_permit", wr_permit, e_perm);
    endtask

    task automatic arm_prefix(string tag);
        cyc(tag, 1, 13'h1555, 8'hAA);
        cyc(tag, 1, 13'h0AAA, 8'h55);
        cyc(tag, 1, 13'h1555, 8'hA0);
    endtask

    task automatic release_seq(string tag);
        cyc(tag, 1, 13'h1555, 8'hAA);
        cyc(tag, 1, 13'h0AAA, 8'h55);
        cyc(tag, 1, 13'h1555, 8'h80);
        cyc(tag, 1, 13'h1555, 8'hAA);
        cyc(tag, 1, 13'h0AAA, 8'h55);
        cyc(tag, 1, 13'h1555, 8'h20);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state, ordinary write passes
        cyc("R1", 1, 13'h0123, 8'h5A);
        // R2: unprotected ordinary writes
        cyc("R2", 1, 13'h1FFF, 8'h00);
        cyc("R11", 0, 13'h1555, 8'hAA);
        // R3, R4: arm prefix; R5 armed write passes, next blocked
        arm_prefix("R4");
        cyc("R4", 0, 13'h0, 8'h0);
        cyc("R5", 1, 13'h0040, 8'h77);
        cyc("R5", 1, 13'h0041, 8'h78);
        // R6: blocked while protected
        cyc("R6", 1, 13'h1555, 8'h00);
        // R11: idle gaps inside a sequence
        cyc("R11", 1, 13'h1555, 8'hAA);
        cyc("R11", 0, 13'h0AAA, 8'h55);
        cyc("R11", 1, 13'h0AAA, 8'h55);
        cyc("R9", 1, 13'h1555, 8'h33);   // R9: bad fork data is mismatch
        // R8: mismatch at step 1 restarts on AA at 1555
        cyc("R8", 1, 13'h1555, 8'hAA);
        cyc("R8", 1, 13'h1555, 8'hAA);
        cyc("R8", 1, 13'h0AAA, 8'h55);
        cyc("R9", 1, 13'h1555, 8'h80);
        cyc("R8", 1, 13'h0AAA, 8'hAA);
        // R10: armed write equal to first command pair
        arm_prefix("R10");
        cyc("R10", 1, 13'h1555, 8'hAA);
        cyc("R10", 1, 13'h0AAA, 8'h55);
        // R7: release clears protection
        release_seq("R7");
        cyc("R7", 1, 13'h0100, 8'h11);
        // R2/R3: unprotected command bytes still suppressed
        arm_prefix("R3");
        release_seq("R7");
        // random phase, biased toward command pairs
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [12:0] a;
            logic [7:0]  d;
            bit v;
            r = $urandom_range(0, 15);
            v = (r != 0);
            a = 13'($urandom);
            d = 8'($urandom);
            case (r % 8)
                1, 2: begin a = 13'h1555; d = 8'hAA; end
                3:    begin a = 13'h0AAA; d = 8'h55; end
                4:    begin a = 13'h1555; d = (r > 8) ? 8'hA0 : 8'h80; end
                5:    begin a = 13'h1555; d = 8'h20; end
                default: ;
            endcase
            cyc("R8", v, a, d);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule